// File: doc/BRIEF.md
# Load/Store Effective-Address Sequencer

This block runs the data-movement instructions of a 16-bit machine with eight general registers. When a new instruction is offered while the block is idle, the block captures the instruction, the incremented program counter and the register values it needs. It forms the effective address and then drives a synchronous memory request port for as many transactions as the addressing mode needs. A load's result goes back to the register file through a write-back port. A one-cycle done pulse marks the end of every sequence.

Four address forms are covered: counter-relative, pointer-through-memory (indirect), register-plus-offset, and the address-only form. The address-only form computes an address and returns it as a register value without touching memory. The indirect form is the only one that needs two memory transactions. The first reads a pointer word, and the second is the real data access at that pointer. The register file, the memory and instruction fetch are outside the block. The block tells the register file which base and source registers to read by decoding the offered instruction word combinationally.

Top module: `ldst_agu_seq`

## Requirements
- R1: After a synchronous active-low reset the block is idle: `idle`=1, `mem_req`=0, `reg_we`=0 and `done`=0.
- R2: Opcodes 0010 (load) and 0011 (store) in bits [15:12] use the address `pc_inc` + sign-extended bits [8:0], computed modulo 2^16.
- R3: Opcodes 0110 (load) and 0111 (store) use the address `base_val` + sign-extended bits [5:0]. `base_sel` shows bits [8:6] and `src_sel` shows bits [11:9] of `instr` combinationally.
- R4: Opcodes 1010 (load) and 1011 (store) first read memory at `pc_inc` + sign-extended bits [8:0], and then do the data access at the word that read returns.
- R5: Opcode 1110 writes `pc_inc` + sign-extended bits [8:0] to the register in bits [11:9] and issues no memory request. For example, 0x30F7 with offset -3 gives 0x30F4.
- R6: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values. A transaction completes in the cycle in which `mem_ready` is high.
- R7: A load raises `reg_we` for exactly one cycle, with `reg_waddr` = bits [11:9] and `reg_wdata` = the word read by the data access. A store raises `reg_we` never and writes `src_val`, as captured at acceptance, with `mem_we`=1.
- R8: `done` is high for exactly one cycle, in the first idle cycle after a sequence ends. Counting the accepting edge, `done` is seen after 2 + T·(L+1) + W rising edges. Here T is the number of memory transactions, L is the number of wait cycles per transaction, and W is 1 for loads and the address-only form and 0 for stores.
- R9: A `start` that arrives while `idle` is low is ignored, and the running sequence continues unchanged.
- R10: A `start` whose opcode is not one of the seven listed above is ignored: the block stays idle, issues no request and raises no `done`.
- R11: The 9-bit offset reaches -256 to +255 and the 6-bit offset reaches -32 to +31. Address sums wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Offer `instr` for execution (taken only when idle) |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Incremented program counter for the offered instruction |
| base_sel | output | 3 | Base register index decoded from `instr` |
| base_val | input | 16 | Value of the register named by `base_sel` |
| src_sel | output | 3 | Data register index decoded from `instr` |
| src_val | input | 16 | Value of the register named by `src_sel` (store data) |
| idle | output | 1 | Block can accept an instruction |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Current transaction completes this cycle |
| reg_we | output | 1 | Register write-back strobe |
| reg_waddr | output | 3 | Register write-back index |
| reg_wdata | output | 16 | Register write-back value |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions take for granted that the memory raises `mem_ready` only in answer to a pending request and that `mem_rdata` is valid whenever `mem_ready` is high. They also assume that `instr`, `pc_inc`, `base_val` and `src_val` need to be valid only in the cycle the block accepts them. The bench's memory model derives `mem_ready` from `mem_req` and a per-test wait count, and drives read data only alongside ready. The bench changes the instruction inputs only on falling edges, and during a busy cycle it offers a deliberately different instruction to show that the block ignores it.

// File: rtl/ldst_agu_pkg.sv
`timescale 1ns/1ps
// Package: ldst_agu_pkg
// Shared constants and types for the load/store effective-address sequencer.
// Assumes a 4-bit opcode in the top bits of every instruction word.
package ldst_agu_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_LD_PCREL = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_ST_PCREL = 4'b0011;
    localparam logic [OPC_W-1:0] OPC_LD_PTR   = 4'b1010;
    localparam logic [OPC_W-1:0] OPC_ST_PTR   = 4'b1011;
    localparam logic [OPC_W-1:0] OPC_LD_BASE  = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_ST_BASE  = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_ADDR_ONLY = 4'b1110;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ADDR,
        SQ_PTR,
        SQ_DATA,
        SQ_WB
    } seq_state_e;

    typedef enum logic [2:0] {
        AM_NONE,
        AM_PCREL,
        AM_INDIRECT,
        AM_BASE,
        AM_ADDRONLY
    } addr_mode_e;

    typedef struct packed {
        addr_mode_e mode;
        logic       is_store;
    } op_ctl_t;

endpackage

// File: rtl/ldst_op_decode.sv
`timescale 1ns/1ps
// Module: ldst_op_decode
// Combinational decode of an instruction word into its addressing mode, its
// direction, its register indices and both sign-extended offsets.
// Assumes the layout opcode | data index | base index | offset, packed from
// the top bit down; the counter offset spans every bit below the data index.
module ldst_op_decode
    import ldst_agu_pkg::*;
#(
    parameter int INSN_W = 16,
    parameter int REG_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic [INSN_W-1:0] insn,
    output op_ctl_t           ctl,
    output logic [REG_W-1:0]  data_idx,
    output logic [REG_W-1:0]  base_idx,
    output logic [DATA_W-1:0] pcoff_ext,
    output logic [DATA_W-1:0] boff_ext
);

    localparam int OPC_LSB  = INSN_W - OPC_W;
    localparam int DIDX_LSB = OPC_LSB - REG_W;
    localparam int BIDX_LSB = DIDX_LSB - REG_W;
    localparam int PCOFF_W  = DIDX_LSB;
    localparam int BOFF_W   = BIDX_LSB;

    logic [OPC_W-1:0] opc;

    assign opc      = insn[INSN_W-1:OPC_LSB];
    assign data_idx = insn[DIDX_LSB +: REG_W];
    assign base_idx = insn[BIDX_LSB +: REG_W];

    // Sign-extend both offset fields to the data width.
    assign pcoff_ext = {{(DATA_W-PCOFF_W){insn[PCOFF_W-1]}}, insn[PCOFF_W-1:0]};
    assign boff_ext  = {{(DATA_W-BOFF_W){insn[BOFF_W-1]}}, insn[BOFF_W-1:0]};

    // Map the opcode to an addressing mode and a direction.
    always_comb begin
        ctl.mode     = AM_NONE;
        ctl.is_store = 1'b0;
        case (opc)
            OPC_LD_PCREL:  ctl.mode = AM_PCREL;
            OPC_ST_PCREL:  begin ctl.mode = AM_PCREL;    ctl.is_store = 1'b1; end
            OPC_LD_PTR:    ctl.mode = AM_INDIRECT;
            OPC_ST_PTR:    begin ctl.mode = AM_INDIRECT; ctl.is_store = 1'b1; end
            OPC_LD_BASE:   ctl.mode = AM_BASE;
            OPC_ST_BASE:   begin ctl.mode = AM_BASE;     ctl.is_store = 1'b1; end
            OPC_ADDR_ONLY: ctl.mode = AM_ADDRONLY;
            default:       ctl.mode = AM_NONE;
        endcase
    end

endmodule

// File: rtl/ldst_addr_gen.sv
`timescale 1ns/1ps
// Module: ldst_addr_gen
// Forms the effective address from captured operands: the base register plus
// the short offset in register-plus-offset mode, and the incremented counter
// plus the long offset in every other mode. SHARED_ADDER picks either one adder
// behind operand muxes or two adders feeding a result mux.
// Assumes its operands are held stable by the caller (captured context).
module ldst_addr_gen
    import ldst_agu_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  addr_mode_e        mode,
    input  logic [DATA_W-1:0] pc_val,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] pcoff_ext,
    input  logic [DATA_W-1:0] boff_ext,
    output logic [DATA_W-1:0] ea
);

    logic use_base;

    assign use_base = (mode == AM_BASE);

    generate
        if (SHARED_ADDER) begin : g_shared
            logic [DATA_W-1:0] opa;
            logic [DATA_W-1:0] opb;
            // Select operands first, then add once.
            always_comb begin
                opa = use_base ? base_val : pc_val;
                opb = use_base ? boff_ext : pcoff_ext;
                ea  = opa + opb;
            end
        end else begin : g_split
            logic [DATA_W-1:0] sum_pc;
            logic [DATA_W-1:0] sum_base;
            // Add both candidates in parallel, then select.
            always_comb begin
                sum_pc   = pc_val + pcoff_ext;
                sum_base = base_val + boff_ext;
                ea       = use_base ? sum_base : sum_pc;
            end
        end
    endgenerate

endmodule

// File: rtl/ldst_seq_fsm.sv
`timescale 1ns/1ps
// Module: ldst_seq_fsm
// Sequencer for one data-movement instruction: address capture, optional
// pointer read, data access and register write-back, ending with a registered
// one-cycle done pulse. Each memory state holds its request until ready.
// Assumes the context (mode, direction, store data) is held by the caller from
// acceptance until the sequence ends.
module ldst_seq_fsm
    import ldst_agu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  addr_mode_e        dec_mode,
    input  addr_mode_e        ctx_mode,
    input  logic              ctx_store,
    input  logic [DATA_W-1:0] ctx_src,
    input  logic [DATA_W-1:0] ea,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              accept,
    output logic              idle,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              reg_we,
    output logic [DATA_W-1:0] wb_data,
    output logic              done
);

    seq_state_e        state;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] wb_q;
    logic              done_q;

    assign idle   = (state == SQ_IDLE);
    assign accept = idle && start && (dec_mode != AM_NONE);

    // Drive the memory and write-back ports from the current state.
    always_comb begin
        mem_req   = (state == SQ_PTR) || (state == SQ_DATA);
        mem_we    = (state == SQ_DATA) && ctx_store;
        mem_addr  = addr_q;
        mem_wdata = ctx_src;
        reg_we    = (state == SQ_WB);
        wb_data   = wb_q;
        done      = done_q;
    end

    // Advance the sequence and capture addresses, pointers and load data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            addr_q <= '0;
            wb_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (accept) begin
                        state <= SQ_ADDR;
                    end
                end
                SQ_ADDR: begin
                    addr_q <= ea;
                    case (ctx_mode)
                        AM_ADDRONLY: begin
                            wb_q  <= ea;
                            state <= SQ_WB;
                        end
                        AM_INDIRECT: state <= SQ_PTR;
                        default:     state <= SQ_DATA;
                    endcase
                end
                SQ_PTR: begin
                    if (mem_ready) begin
                        addr_q <= mem_rdata;
                        state  <= SQ_DATA;
                    end
                end
                SQ_DATA: begin
                    if (mem_ready) begin
                        if (ctx_store) begin
                            done_q <= 1'b1;
                            state  <= SQ_IDLE;
                        end else begin
                            wb_q  <= mem_rdata;
                            state <= SQ_WB;
                        end
                    end
                end
                SQ_WB: begin
                    done_q <= 1'b1;
                    state  <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ldst_agu_seq.sv
`timescale 1ns/1ps
// Module: ldst_agu_seq (top)
// Load/store effective-address sequencer. It decodes the offered instruction,
// captures the instruction fields and operand values on acceptance, forms the
// effective address and sequences the memory transactions and write-back.
// Assumes base_val and src_val belong to base_sel and src_sel in the cycle
// where start is high, and that mem_rdata is valid whenever mem_ready is high.
module ldst_agu_seq
    import ldst_agu_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int REG_W        = 3,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W-1:0] pc_inc,
    output logic [REG_W-1:0]  base_sel,
    input  logic [DATA_W-1:0] base_val,
    output logic [REG_W-1:0]  src_sel,
    input  logic [DATA_W-1:0] src_val,
    output logic              idle,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              reg_we,
    output logic [REG_W-1:0]  reg_waddr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              done
);

    op_ctl_t           dec_ctl;
    logic [REG_W-1:0]  dec_didx;
    logic [REG_W-1:0]  dec_bidx;
    logic [DATA_W-1:0] dec_pcoff;
    logic [DATA_W-1:0] dec_boff;

    addr_mode_e        ctx_mode;
    logic              ctx_store;
    logic [REG_W-1:0]  ctx_didx;
    logic [DATA_W-1:0] ctx_pc;
    logic [DATA_W-1:0] ctx_base;
    logic [DATA_W-1:0] ctx_src;
    logic [DATA_W-1:0] ctx_pcoff;
    logic [DATA_W-1:0] ctx_boff;

    logic              accept;
    logic [DATA_W-1:0] ea;

    ldst_op_decode #(
        .INSN_W (DATA_W),
        .REG_W  (REG_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .insn      (instr),
        .ctl       (dec_ctl),
        .data_idx  (dec_didx),
        .base_idx  (dec_bidx),
        .pcoff_ext (dec_pcoff),
        .boff_ext  (dec_boff)
    );

    assign base_sel  = dec_bidx;
    assign src_sel   = dec_didx;
    assign reg_waddr = ctx_didx;

    // Capture the decoded instruction and its operands when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_mode  <= AM_NONE;
            ctx_store <= 1'b0;
            ctx_didx  <= '0;
            ctx_pc    <= '0;
            ctx_base  <= '0;
            ctx_src   <= '0;
            ctx_pcoff <= '0;
            ctx_boff  <= '0;
        end else if (accept) begin
            ctx_mode  <= dec_ctl.mode;
            ctx_store <= dec_ctl.is_store;
            ctx_didx  <= dec_didx;
            ctx_pc    <= pc_inc;
            ctx_base  <= base_val;
            ctx_src   <= src_val;
            ctx_pcoff <= dec_pcoff;
            ctx_boff  <= dec_boff;
        end
    end

    ldst_addr_gen #(
        .DATA_W       (DATA_W),
        .SHARED_ADDER (SHARED_ADDER)
    ) u_addr (
        .mode      (ctx_mode),
        .pc_val    (ctx_pc),
        .base_val  (ctx_base),
        .pcoff_ext (ctx_pcoff),
        .boff_ext  (ctx_boff),
        .ea        (ea)
    );

    ldst_seq_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dec_mode  (dec_ctl.mode),
        .ctx_mode  (ctx_mode),
        .ctx_store (ctx_store),
        .ctx_src   (ctx_src),
        .ea        (ea),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .accept    (accept),
        .idle      (idle),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .reg_we    (reg_we),
        .wb_data   (reg_wdata),
        .done      (done)
    );

endmodule

// File: rtl/ldst_agu_seq_chk.sv
`timescale 1ns/1ps
// Module: ldst_agu_seq_chk
// Port-level protocol checks for ldst_agu_seq, attached with bind.
// Assumes mem_ready is raised only in answer to a pending request.
module ldst_agu_seq_chk
    import ldst_agu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] instr,
    input logic              idle,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              reg_we,
    input logic              done
);

    logic [OPC_W-1:0] opc;
    logic             opc_known;

    // Classify the offered opcode independently of the decoder.
    always_comb begin
        opc       = instr[DATA_W-1 -: OPC_W];
        opc_known = (opc == OPC_LD_PCREL) || (opc == OPC_ST_PCREL) ||
                    (opc == OPC_LD_PTR)   || (opc == OPC_ST_PTR)   ||
                    (opc == OPC_LD_BASE)  || (opc == OPC_ST_BASE)  ||
                    (opc == OPC_ADDR_ONLY);
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mem_req && !reg_we));

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_wdata)));

    p_wb_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (!reg_we && done));

    p_wb_no_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !mem_req);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> idle);

    p_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && opc_known) |=> !idle);

    p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && !opc_known) |=> (idle && !done));

endmodule

bind ldst_agu_seq ldst_agu_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .instr     (instr),
    .idle      (idle),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .reg_we    (reg_we),
    .done      (done)
);

// File: tb/ldst_agu_seq_bench.sv
`timescale 1ns/1ps
// Directed bench for ldst_agu_seq: one task per scenario, with a memory model
// whose wait count is set per test.
module ldst_agu_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] pc_inc = '0;
    logic [15:0] base_val = '0;
    logic [15:0] src_val = '0;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [2:0]  base_sel;
    logic [2:0]  src_sel;
    logic        idle;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        reg_we;
    logic [2:0]  reg_waddr;
    logic [15:0] reg_wdata;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] mem_m [logic [15:0]];
    int          lat = 0;
    int          wcnt = 0;
    int          txn_n = 0;
    logic [15:0] txn_a [4];
    logic        txn_w [4];

    always #2.5 clk = ~clk;

    ldst_agu_seq u_ldst_agu_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .instr     (instr),
        .pc_inc    (pc_inc),
        .base_sel  (base_sel),
        .base_val  (base_val),
        .src_sel   (src_sel),
        .src_val   (src_val),
        .idle      (idle),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .done      (done)
    );

    function automatic logic [15:0] mrd(input logic [15:0] a);
        return mem_m.exists(a) ? mem_m[a] : 16'h0000;
    endfunction

    // Memory model: complete and log transactions at the rising edge.
    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            if (txn_n < 4) begin
                txn_a[txn_n] = mem_addr;
                txn_w[txn_n] = mem_we;
            end
            txn_n++;
            if (mem_we) mem_m[mem_addr] = mem_wdata;
            wcnt = 0;
        end else if (mem_req) begin
            wcnt++;
        end else begin
            wcnt = 0;
        end
    end

    // Memory model: answer on the falling edge after lat wait cycles.
    always @(negedge clk) begin
        mem_ready = mem_req && (wcnt >= lat);
        mem_rdata = mem_ready ? mrd(mem_addr) : 16'h0000;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Run one instruction and check its timing, transactions and write-back.
    task automatic do_op(input string req, input logic [15:0] ins,
                         input logic [15:0] pc, input logic [15:0] bv,
                         input logic [15:0] sv, input int l, input int ops,
                         input bit st, input logic [15:0] a0,
                         input logic [15:0] a1, input bit wb,
                         input logic [2:0] widx, input logic [15:0] wval,
                         input bit poke);
        int          n;
        int          wcount;
        logic [2:0]  got_idx;
        logic [15:0] got_val;
        bit          idle_seen;
        lat = l;
        txn_n = 0;
        instr = ins;
        pc_inc = pc;
        base_val = bv;
        src_val = sv;
        start = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start = 1'b0;
        instr = 16'h0000;
        wcount = 0;
        got_idx = '0;
        got_val = '0;
        idle_seen = 1'b0;
        while (!done && n < 200) begin
            if (reg_we) begin
                wcount++;
                got_idx = reg_waddr;
                got_val = reg_wdata;
            end
            if (idle) idle_seen = 1'b1;
            if (poke && n == 2) begin
                start = 1'b1;
                instr = 16'hE1FF;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R8", {req, " edges to done"}, n, 2 + ops * (l + 1) + (wb ? 1 : 0));
        chk("R6", {req, " transaction count"}, txn_n, ops);
        if (ops >= 1) begin
            chk(req, "first address", txn_a[0], a0);
            chk(req, "first direction", txn_w[0], (ops == 1) ? st : 1'b0);
        end
        if (ops == 2) begin
            chk("R4", "second address", txn_a[1], a1);
            chk("R4", "second direction", txn_w[1], st);
        end
        chk("R7", {req, " write-back count"}, wcount, wb ? 1 : 0);
        if (wb) begin
            chk("R7", {req, " write-back index"}, got_idx, widx);
            chk("R7", {req, " write-back value"}, got_val, wval);
        end
        chk("R9", {req, " idle during sequence"}, idle_seen, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk("R8", {req, " done single pulse"}, done, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "idle after reset", idle, 1'b1);
        chk("R1", "mem_req after reset", mem_req, 1'b0);
        chk("R1", "reg_we after reset", reg_we, 1'b0);
        chk("R1", "done after reset", done, 1'b0);
    endtask

    task automatic t_addr_only();
        // R5: 0x30F7 with offset -3 into register 5
        do_op("R5", 16'hEBFD, 16'h30F7, 16'h0, 16'h0, 0, 0, 1'b0,
              16'h0, 16'h0, 1'b1, 3'd5, 16'h30F4, 1'b0);
        // R11: offset -1 from 0x0000 wraps to 0xFFFF
        do_op("R11", 16'hE1FF, 16'h0000, 16'h0, 16'h0, 1, 0, 1'b0,
              16'h0, 16'h0, 1'b1, 3'd0, 16'hFFFF, 1'b0);
    endtask

    task automatic t_pcrel();
        mem_m[16'h300A] = 16'hBEEF;
        mem_m[16'h1100] = 16'h00A5;
        do_op("R2", 16'h240A, 16'h3000, 16'h0, 16'h0, 0, 1, 1'b0,
              16'h300A, 16'h0, 1'b1, 3'd2, 16'hBEEF, 1'b0);
        // R11: most negative 9-bit offset, store
        do_op("R11", 16'h3700, 16'h4000, 16'h0, 16'h1234, 2, 1, 1'b1,
              16'h3F00, 16'h0, 1'b0, 3'd0, 16'h0, 1'b0);
        chk("R7", "stored word at 0x3F00", mrd(16'h3F00), 16'h1234);
        // R11: most positive 9-bit offset, load
        do_op("R11", 16'h22FF, 16'h1001, 16'h0, 16'h0, 0, 1, 1'b0,
              16'h1100, 16'h0, 1'b1, 3'd1, 16'h00A5, 1'b0);
    endtask

    task automatic t_busy_ignore();
        // R9: an address-only start offered mid-sequence must not run
        do_op("R9", 16'h240A, 16'h3000, 16'h0, 16'h0, 2, 1, 1'b0,
              16'h300A, 16'h0, 1'b1, 3'd2, 16'hBEEF, 1'b1);
        repeat (3) @(negedge clk);
        chk("R9", "no extra done after busy start", done, 1'b0);
        chk("R9", "idle after busy start", idle, 1'b1);
    endtask

    task automatic t_base();
        mem_m[16'h201D] = 16'h4321;
        instr = 16'h629D;
        #1;
        chk("R3", "base_sel decode", base_sel, 3'd2);
        chk("R3", "src_sel decode", src_sel, 3'd1);
        do_op("R3", 16'h629D, 16'h0000, 16'h2000, 16'h0, 1, 1, 1'b0,
              16'h201D, 16'h0, 1'b1, 3'd1, 16'h4321, 1'b0);
        // R11: most negative 6-bit offset wraps below zero
        do_op("R11", 16'h78E0, 16'h0000, 16'h0010, 16'h0F0F, 0, 1, 1'b1,
              16'hFFF0, 16'h0, 1'b0, 3'd0, 16'h0, 1'b0);
        chk("R7", "stored word at 0xFFF0", mrd(16'hFFF0), 16'h0F0F);
    endtask

    task automatic t_indirect();
        mem_m[16'h30FC] = 16'h5555;
        mem_m[16'h5555] = 16'h0777;
        do_op("R4", 16'hA7FC, 16'h3100, 16'h0, 16'h0, 1, 2, 1'b0,
              16'h30FC, 16'h5555, 1'b1, 3'd3, 16'h0777, 1'b0);
        mem_m[16'h0203] = 16'h0A0A;
        do_op("R4", 16'hBC03, 16'h0200, 16'h0, 16'hCAFE, 2, 2, 1'b1,
              16'h0203, 16'h0A0A, 1'b0, 3'd0, 16'h0, 1'b0);
        chk("R4", "stored word at pointer", mrd(16'h0A0A), 16'hCAFE);
        chk("R4", "pointer word untouched", mrd(16'h0203), 16'h0A0A);
    endtask

    task automatic t_unknown_opcode();
        bit left_idle;
        bit saw_req;
        bit saw_done;
        left_idle = 1'b0;
        saw_req = 1'b0;
        saw_done = 1'b0;
        instr = 16'h1234;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            if (!idle) left_idle = 1'b1;
            if (mem_req) saw_req = 1'b1;
            if (done) saw_done = 1'b1;
            @(negedge clk);
        end
        chk("R10", "left idle on unknown opcode", left_idle, 1'b0);
        chk("R10", "request on unknown opcode", saw_req, 1'b0);
        chk("R10", "done on unknown opcode", saw_done, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_addr_only();
        t_pcrel();
        t_busy_ignore();
        t_base();
        t_indirect();
        t_unknown_opcode();
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule